// File: doc/BRIEF.md
# Bidirectional Doorbell and Interrupt Shim

This block is the signalling point between a host processor and an embedded DSP core. It keeps one 64-bit doorbell register per direction. The host-to-DSP register is called H2D and the DSP-to-host register is called D2H. In each doorbell the top two bits are flags, a message-pending flag (BUSY) and a completion flag (DONE). The remaining 62 bits are payload that the writer controls. The block also keeps one interrupt-enable mask per side. From the flags and the masks it derives one level-sensitive interrupt toward each processor. The message bodies themselves travel through a shared mailbox memory outside this block.

Either side posts a message by setting BUSY in its outbound doorbell. The receiver answers by updating that same register: it clears BUSY and sets DONE in a single write, or it sets DONE alone. The sender then clears DONE once it has taken the reply. Each side has its own write port, and every write carries a per-bit write enable. A flag can therefore be changed without a read-modify-write race against the other side. When the DSP raises BUSY with a fatal-error signature in the low word of D2H, the block also exposes a mailbox offset that is carried in bits 47:32.

Top module: `ipc_doorbell_shim`

## Requirements
- R1: After reset both doorbells read 0. Both masks read 0b10, which means the BUSY source is enabled and the DONE source is masked. Both interrupts are low.
- R2: The register select codes are 0 for H2D, 1 for D2H, 2 for the host mask and 3 for the DSP mask. BUSY is bit 63 and DONE is bit 62 of each doorbell. A write changes only the bits whose write-enable bit is 1. The new value is visible on both read ports from the cycle after the write edge. Mask registers use bits 1:0 and read as zero above that.
- R3: `host_irq` = (D2H BUSY and not host mask bit 0) or (H2D DONE and not host mask bit 1).
- R4: `dsp_irq` = (H2D BUSY and not DSP mask bit 0) or (D2H DONE and not DSP mask bit 1).
- R5: Only the host port can write the host mask, and only the DSP port can write the DSP mask. A write to the other side's mask is ignored.
- R6: When both ports write the same doorbell in one cycle, bits enabled by only one port take that port's value. Bits enabled by both ports take the owner's value. The host owns H2D and the DSP owns D2H.
- R7: `panic_valid` is 1 when D2H BUSY is set and (D2H[31:0] & 0x0FFFF000) == 0x0DEAD000. When it is 1, `panic_offset` equals D2H[47:32]; otherwise `panic_offset` is 0.
- R8: In a cycle with no write to a register, that register keeps its value.
- R9: A full exchange in each direction works from the reset masks. The sequence is post, acknowledge, and clear or unmask, and it raises and drops each interrupt in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_sel | input | 2 | Host write register select |
| host_wr_data | input | 64 | Host write data |
| host_wr_mask | input | 64 | Host per-bit write enable |
| host_rd_sel | input | 2 | Host read register select |
| host_rd_data | output | 64 | Host read data |
| dsp_wr_en | input | 1 | DSP write strobe |
| dsp_wr_sel | input | 2 | DSP write register select |
| dsp_wr_data | input | 64 | DSP write data |
| dsp_wr_mask | input | 64 | DSP per-bit write enable |
| dsp_rd_sel | input | 2 | DSP read register select |
| dsp_rd_data | output | 64 | DSP read data |
| host_irq | output | 1 | Level interrupt to the host |
| dsp_irq | output | 1 | Level interrupt to the DSP |
| panic_valid | output | 1 | D2H carries a fatal-error signature |
| panic_offset | output | 16 | Mailbox offset from D2H bits 47:32 |

## Verification
A write is captured on the rising edge where its strobe is sampled. The register contents, both interrupts and the error-signature outputs all reflect that write from that edge onward. Reads are combinational from the registers, so a read-select change shows up in the same cycle. The bench drives its inputs half a nanosecond after the falling edge. It reads back shortly after that and compares every output against its behavioural model at each falling edge. Every result is therefore sampled exactly one edge after the stimulus that caused it.

// File: rtl/ipc_shim_pkg.sv
package ipc_shim_pkg;

    localparam int SEL_W  = 2;
    localparam int MASK_W = 2;

    // mask bit positions per interrupt source
    localparam int MBIT_BUSY = 0;
    localparam int MBIT_DONE = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_H2D   = 2'd0,
        SEL_D2H   = 2'd1,
        SEL_HMASK = 2'd2,
        SEL_DMASK = 2'd3
    } reg_sel_e;

    // reset value: BUSY source enabled, DONE source masked
    localparam logic [MASK_W-1:0] MASK_RST = MASK_W'(1) << MBIT_DONE;

endpackage

// File: rtl/ipc_db_merge.sv
// Merges the two ports' masked writes into one doorbell; owner wins on overlap.
module ipc_db_merge #(
    parameter int W = 64
) (
    input  logic [W-1:0] cur,
    input  logic         own_we,
    input  logic [W-1:0] own_data,
    input  logic [W-1:0] own_mask,
    input  logic         peer_we,
    input  logic [W-1:0] peer_data,
    input  logic [W-1:0] peer_mask,
    output logic [W-1:0] nxt
);
    logic [W-1:0] after_peer;

    always_comb begin
        after_peer = cur;
        if (peer_we) begin
            after_peer = (cur & ~peer_mask) | (peer_data & peer_mask);
        end
        nxt = after_peer;
        if (own_we) begin
            nxt = (after_peer & ~own_mask) | (own_data & own_mask);
        end
    end
endmodule

// File: rtl/ipc_irq_gen.sv
// One side's interrupt from its two sources and its enable mask.
module ipc_irq_gen
    import ipc_shim_pkg::*;
(
    input  logic              busy_src,
    input  logic              done_src,
    input  logic [MASK_W-1:0] mask,
    output logic              irq
);
    logic busy_hit;
    logic done_hit;

    always_comb begin
        busy_hit = busy_src && !mask[MBIT_BUSY];
        done_hit = done_src && !mask[MBIT_DONE];
        irq      = busy_hit || done_hit;
    end
endmodule

// File: rtl/ipc_panic_decode.sv
// Detects a fatal-error signature in the DSP-to-host doorbell.
module ipc_panic_decode #(
    parameter int          OFF_LSB  = 32,
    parameter int          OFF_W    = 16,
    parameter logic [31:0] SIG      = 32'h0DEA_D000,
    parameter logic [31:0] SIG_MASK = 32'h0FFF_F000
) (
    input  logic                     busy,
    input  logic [OFF_LSB+OFF_W-1:0] word,
    output logic                     valid,
    output logic [OFF_W-1:0]         offset
);
    logic [OFF_LSB-1:0] sig_part;
    logic               sig_hit;

    always_comb begin
        sig_part = word[OFF_LSB-1:0];
        sig_hit  = (32'(sig_part) & SIG_MASK) == SIG;
        valid    = busy && sig_hit;
        offset   = valid ? word[OFF_LSB +: OFF_W] : '0;
    end
endmodule

// File: rtl/ipc_doorbell_shim.sv
module ipc_doorbell_shim
    import ipc_shim_pkg::*;
#(
    parameter int          DB_W       = 64,
    parameter int          OFF_LSB    = 32,
    parameter int          OFF_W      = 16,
    parameter logic [31:0] PANIC_SIG  = 32'h0DEA_D000,
    parameter logic [31:0] PANIC_MASK = 32'h0FFF_F000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_en,
    input  logic [1:0]      host_wr_sel,
    input  logic [DB_W-1:0] host_wr_data,
    input  logic [DB_W-1:0] host_wr_mask,
    input  logic [1:0]      host_rd_sel,
    output logic [DB_W-1:0] host_rd_data,
    input  logic            dsp_wr_en,
    input  logic [1:0]      dsp_wr_sel,
    input  logic [DB_W-1:0] dsp_wr_data,
    input  logic [DB_W-1:0] dsp_wr_mask,
    input  logic [1:0]      dsp_rd_sel,
    output logic [DB_W-1:0] dsp_rd_data,
    output logic            host_irq,
    output logic            dsp_irq,
    output logic            panic_valid,
    output logic [OFF_W-1:0] panic_offset
);
    localparam int BUSY_BIT = DB_W - 1;
    localparam int DONE_BIT = DB_W - 2;
    localparam int N_DB     = 2;
    localparam int DEC_W    = OFF_LSB + OFF_W;

    typedef struct packed {
        logic [N_DB-1:0][DB_W-1:0] db;
        logic [MASK_W-1:0]         hmask;
        logic [MASK_W-1:0]         dmask;
    } state_t;

    state_t st_d, st_q;
    logic [N_DB-1:0][DB_W-1:0] db_nxt;

    // doorbell merge, one per direction; index equals its select code
    for (genvar g = 0; g < N_DB; g++) begin : g_db
        logic            host_hit;
        logic            dsp_hit;
        logic            own_we, peer_we;
        logic [DB_W-1:0] own_d, own_m, peer_d, peer_m;

        assign host_hit = host_wr_en && (host_wr_sel == SEL_W'(g));
        assign dsp_hit  = dsp_wr_en  && (dsp_wr_sel  == SEL_W'(g));

        if (g == int'(SEL_H2D)) begin : g_host_owner
            assign own_we  = host_hit;
            assign own_d   = host_wr_data;
            assign own_m   = host_wr_mask;
            assign peer_we = dsp_hit;
            assign peer_d  = dsp_wr_data;
            assign peer_m  = dsp_wr_mask;
        end else begin : g_dsp_owner
            assign own_we  = dsp_hit;
            assign own_d   = dsp_wr_data;
            assign own_m   = dsp_wr_mask;
            assign peer_we = host_hit;
            assign peer_d  = host_wr_data;
            assign peer_m  = host_wr_mask;
        end

        ipc_db_merge #(.W(DB_W)) u_merge (
            .cur       (st_q.db[g]),
            .own_we    (own_we),
            .own_data  (own_d),
            .own_mask  (own_m),
            .peer_we   (peer_we),
            .peer_data (peer_d),
            .peer_mask (peer_m),
            .nxt       (db_nxt[g])
        );
    end

    function automatic logic [DB_W-1:0] read_reg(input state_t s, input logic [1:0] sel);
        logic [DB_W-1:0] r;
        case (reg_sel_e'(sel))
            SEL_H2D:   r = s.db[SEL_H2D];
            SEL_D2H:   r = s.db[SEL_D2H];
            SEL_HMASK: r = DB_W'(s.hmask);
            default:   r = DB_W'(s.dmask);
        endcase
        return r;
    endfunction

    always_comb begin
        st_d    = st_q;
        st_d.db = db_nxt;
        if (host_wr_en && reg_sel_e'(host_wr_sel) == SEL_HMASK) begin
            st_d.hmask = (st_q.hmask & ~host_wr_mask[MASK_W-1:0])
                       | (host_wr_data[MASK_W-1:0] & host_wr_mask[MASK_W-1:0]);
        end
        if (dsp_wr_en && reg_sel_e'(dsp_wr_sel) == SEL_DMASK) begin
            st_d.dmask = (st_q.dmask & ~dsp_wr_mask[MASK_W-1:0])
                       | (dsp_wr_data[MASK_W-1:0] & dsp_wr_mask[MASK_W-1:0]);
        end
        host_rd_data = read_reg(st_q, host_rd_sel);
        dsp_rd_data  = read_reg(st_q, dsp_rd_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.db    <= '0;
            st_q.hmask <= MASK_RST;
            st_q.dmask <= MASK_RST;
        end else begin
            st_q <= st_d;
        end
    end

    ipc_irq_gen u_host_irq (
        .busy_src (st_q.db[SEL_D2H][BUSY_BIT]),
        .done_src (st_q.db[SEL_H2D][DONE_BIT]),
        .mask     (st_q.hmask),
        .irq      (host_irq)
    );

    ipc_irq_gen u_dsp_irq (
        .busy_src (st_q.db[SEL_H2D][BUSY_BIT]),
        .done_src (st_q.db[SEL_D2H][DONE_BIT]),
        .mask     (st_q.dmask),
        .irq      (dsp_irq)
    );

    ipc_panic_decode #(
        .OFF_LSB  (OFF_LSB),
        .OFF_W    (OFF_W),
        .SIG      (PANIC_SIG),
        .SIG_MASK (PANIC_MASK)
    ) u_panic (
        .busy   (st_q.db[SEL_D2H][BUSY_BIT]),
        .word   (st_q.db[SEL_D2H][DEC_W-1:0]),
        .valid  (panic_valid),
        .offset (panic_offset)
    );
endmodule

// File: rtl/ipc_doorbell_shim_chk.sv
module ipc_doorbell_shim_chk #(
    parameter int DB_W   = 64,
    parameter int MASK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic [1:0]        host_wr_sel,
    input logic [DB_W-1:0]   host_wr_data,
    input logic [DB_W-1:0]   host_wr_mask,
    input logic              dsp_wr_en,
    input logic [1:0]        dsp_wr_sel,
    input logic [DB_W-1:0]   dsp_wr_data,
    input logic [DB_W-1:0]   dsp_wr_mask,
    input logic [DB_W-1:0]   h2d,
    input logic [DB_W-1:0]   d2h,
    input logic [MASK_W-1:0] hmask,
    input logic [MASK_W-1:0] dmask,
    input logic              host_irq,
    input logic              dsp_irq,
    input logic              panic_valid
);
    AST_H2D_OWNER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_wr_sel == 2'd0) |=> (((h2d ^ $past(host_wr_data)) & $past(host_wr_mask)) == '0)); // R6

    AST_D2H_OWNER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_wr_en && dsp_wr_sel == 2'd1) |=> (((d2h ^ $past(dsp_wr_data)) & $past(dsp_wr_mask)) == '0)); // R6

    AST_H2D_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_wr_en && host_wr_sel == 2'd0) && !(dsp_wr_en && dsp_wr_sel == 2'd0)) |=> $stable(h2d)); // R8

    AST_D2H_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_wr_en && host_wr_sel == 2'd1) && !(dsp_wr_en && dsp_wr_sel == 2'd1)) |=> $stable(d2h)); // R8

    AST_HMASK_HOST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr_en && host_wr_sel == 2'd2) |=> $stable(hmask)); // R5

    AST_DMASK_DSP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsp_wr_en && dsp_wr_sel == 2'd3) |=> $stable(dmask)); // R5

    AST_HOST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hmask == 2'b11) |-> !host_irq); // R3

    AST_DSP_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dmask == 2'b11) |-> !dsp_irq); // R4

    AST_PANIC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        panic_valid |-> d2h[DB_W-1]); // R7
endmodule

bind ipc_doorbell_shim ipc_doorbell_shim_chk #(.DB_W(DB_W), .MASK_W(ipc_shim_pkg::MASK_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_wr_sel  (host_wr_sel),
    .host_wr_data (host_wr_data),
    .host_wr_mask (host_wr_mask),
    .dsp_wr_en    (dsp_wr_en),
    .dsp_wr_sel   (dsp_wr_sel),
    .dsp_wr_data  (dsp_wr_data),
    .dsp_wr_mask  (dsp_wr_mask),
    .h2d          (st_q.db[0]),
    .d2h          (st_q.db[1]),
    .hmask        (st_q.hmask),
    .dmask        (st_q.dmask),
    .host_irq     (host_irq),
    .dsp_irq      (dsp_irq),
    .panic_valid  (panic_valid)
);

// File: tb/ipc_doorbell_shim_tb.sv
`timescale 1ns/100ps
module ipc_doorbell_shim_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0, dsp_wr_en = 1'b0;
    logic [1:0]  host_wr_sel = '0, dsp_wr_sel = '0, host_rd_sel = '0, dsp_rd_sel = '0;
    logic [63:0] host_wr_data = '0, host_wr_mask = '0, dsp_wr_data = '0, dsp_wr_mask = '0;
    logic [63:0] host_rd_data, dsp_rd_data;
    logic        host_irq, dsp_irq, panic_valid;
    logic [15:0] panic_offset;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ipc_doorbell_shim dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_sel(host_wr_sel),
        .host_wr_data(host_wr_data), .host_wr_mask(host_wr_mask),
        .host_rd_sel(host_rd_sel), .host_rd_data(host_rd_data),
        .dsp_wr_en(dsp_wr_en), .dsp_wr_sel(dsp_wr_sel),
        .dsp_wr_data(dsp_wr_data), .dsp_wr_mask(dsp_wr_mask),
        .dsp_rd_sel(dsp_rd_sel), .dsp_rd_data(dsp_rd_data),
        .host_irq(host_irq), .dsp_irq(dsp_irq),
        .panic_valid(panic_valid), .panic_offset(panic_offset)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_h2d = '0, m_d2h = '0;
    logic [1:0]  m_hm = 2'b10, m_dm = 2'b10;

    function automatic logic [63:0] put_bits(input logic [63:0] cur, input logic [63:0] d,
                                             input logic [63:0] m);
        logic [63:0] r = cur;
        for (int b = 0; b < 64; b++) if (m[b]) r[b] = d[b];
        return r;
    endfunction

    function automatic logic [63:0] m_read(input logic [1:0] sel);
        case (sel)
            2'd0: return m_h2d;
            2'd1: return m_d2h;
            2'd2: return {62'd0, m_hm};
            default: return {62'd0, m_dm};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_h2d <= '0; m_d2h <= '0; m_hm <= 2'b10; m_dm <= 2'b10;
        end else begin
            logic [63:0] h, d;
            h = m_h2d; d = m_d2h;
            // H2D: host is owner, so its bits are applied last
            if (dsp_wr_en  && dsp_wr_sel  == 2'd0) h = put_bits(h, dsp_wr_data, dsp_wr_mask);
            if (host_wr_en && host_wr_sel == 2'd0) h = put_bits(h, host_wr_data, host_wr_mask);
            // D2H: DSP is owner
            if (host_wr_en && host_wr_sel == 2'd1) d = put_bits(d, host_wr_data, host_wr_mask);
            if (dsp_wr_en  && dsp_wr_sel  == 2'd1) d = put_bits(d, dsp_wr_data, dsp_wr_mask);
            m_h2d <= h; m_d2h <= d;
            if (host_wr_en && host_wr_sel == 2'd2) m_hm <= put_bits({62'd0, m_hm}, host_wr_data, host_wr_mask) & 64'h3;
            if (dsp_wr_en  && dsp_wr_sel  == 2'd3) m_dm <= put_bits({62'd0, m_dm}, dsp_wr_data, dsp_wr_mask) & 64'h3;
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=0x%016h exp=0x%016h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic eh, ed, ep;
        logic [15:0] eo;
        eh = (m_d2h[63] && !m_hm[0]) || (m_h2d[62] && !m_hm[1]);
        ed = (m_h2d[63] && !m_dm[0]) || (m_d2h[62] && !m_dm[1]);
        ep = m_d2h[63] && ((m_d2h[31:0] & 32'h0FFF_F000) == 32'h0DEA_D000);
        eo = ep ? m_d2h[47:32] : 16'h0;
        check(host_rd_data == m_read(host_rd_sel), "R2 host read", host_rd_data, m_read(host_rd_sel));
        check(dsp_rd_data == m_read(dsp_rd_sel), "R2 dsp read", dsp_rd_data, m_read(dsp_rd_sel));
        check(host_irq == eh, "R3 host_irq", 64'(host_irq), 64'(eh));
        check(dsp_irq == ed, "R4 dsp_irq", 64'(dsp_irq), 64'(ed));
        check(panic_valid == ep && panic_offset == eo, "R7 panic", {panic_valid, panic_offset}, {ep, eo});
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk); #0.5;
        host_wr_en = 1'b0; dsp_wr_en = 1'b0;
    endtask

    task automatic do_wr(input logic he, input logic [1:0] hs, input logic [63:0] hd, input logic [63:0] hm,
                         input logic de, input logic [1:0] ds, input logic [63:0] dd, input logic [63:0] dm);
        tick();
        host_wr_en = he; host_wr_sel = hs; host_wr_data = hd; host_wr_mask = hm;
        dsp_wr_en = de; dsp_wr_sel = ds; dsp_wr_data = dd; dsp_wr_mask = dm;
        tick();
    endtask

    task automatic hwr(input logic [1:0] s, input logic [63:0] d, input logic [63:0] m);
        do_wr(1'b1, s, d, m, 1'b0, 2'd0, 64'd0, 64'd0);
    endtask

    task automatic dwr(input logic [1:0] s, input logic [63:0] d, input logic [63:0] m);
        do_wr(1'b0, 2'd0, 64'd0, 64'd0, 1'b1, s, d, m);
    endtask

    task automatic peek(input logic [1:0] s, input logic [63:0] exp, input string tag);
        host_rd_sel = s; dsp_rd_sel = s;
        #0.3;
        check(host_rd_data == exp, tag, host_rd_data, exp);
        check(dsp_rd_data == exp, tag, dsp_rd_data, exp);
    endtask

    task automatic irqs(input logic eh, input logic ed, input string tag);
        check(host_irq == eh && dsp_irq == ed, tag, {host_irq, dsp_irq}, {eh, ed});
    endtask

    localparam logic [63:0] ALL = '1;
    localparam logic [63:0] FLG = 64'hC000_0000_0000_0000;

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        // R1 reset state
        peek(2'd0, 64'd0, "R1 h2d reset");
        peek(2'd1, 64'd0, "R1 d2h reset");
        peek(2'd2, 64'd2, "R1 host mask reset");
        peek(2'd3, 64'd2, "R1 dsp mask reset");
        irqs(1'b0, 1'b0, "R1 irqs reset");
        rst_n = 1'b1;

        // R9 host->DSP exchange: unmask DONE, post, ack, clear
        hwr(2'd2, 64'd0, 64'd2);
        peek(2'd2, 64'd0, "R2 host mask DONE unmasked");
        hwr(2'd0, 64'h8000_0000_0000_1234, ALL);
        irqs(1'b0, 1'b1, "R4 H2D BUSY raises dsp_irq");
        dwr(2'd0, 64'h4000_0000_0000_0000, FLG);
        peek(2'd0, 64'h4000_0000_0000_1234, "R2 ack keeps payload");
        irqs(1'b1, 1'b0, "R3 H2D DONE raises host_irq");
        hwr(2'd0, 64'd0, 64'h4000_0000_0000_0000);
        irqs(1'b0, 1'b0, "R9 host clears DONE");

        // R9 DSP->host exchange
        dwr(2'd1, 64'h8000_0000_0000_00AA, ALL);
        irqs(1'b1, 1'b0, "R3 D2H BUSY raises host_irq");
        hwr(2'd1, 64'h4000_0000_0000_0000, FLG);
        peek(2'd1, 64'h4000_0000_0000_00AA, "R9 host ack single write");
        irqs(1'b0, 1'b0, "R4 D2H DONE masked by reset");
        dwr(2'd3, 64'd0, 64'd3);
        irqs(1'b0, 1'b1, "R4 D2H DONE after unmask");

        // R5 mask ownership
        hwr(2'd3, 64'd3, ALL);
        peek(2'd3, 64'd0, "R5 host cannot write dsp mask");
        dwr(2'd2, 64'd3, ALL);
        peek(2'd2, 64'd0, "R5 dsp cannot write host mask");

        // R6 concurrent writes to H2D
        do_wr(1'b1, 2'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
              1'b1, 2'd0, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000);
        peek(2'd0, 64'hC000_0000_0000_1234, "R6 disjoint bits both land");
        do_wr(1'b1, 2'd0, 64'h0000_0000_0000_5555, ALL, 1'b1, 2'd0, ALL, ALL);
        peek(2'd0, 64'h0000_0000_0000_5555, "R6 host owns H2D overlap");
        do_wr(1'b1, 2'd1, ALL, ALL, 1'b1, 2'd1, 64'h0000_0000_0000_0077, ALL);
        peek(2'd1, 64'h0000_0000_0000_0077, "R6 dsp owns D2H overlap");

        // R7 error signature
        dwr(2'd1, 64'h8000_0ABC_0DEA_D123, ALL);
        check(panic_valid && panic_offset == 16'h0ABC, "R7 signature decode", {panic_valid, panic_offset}, {1'b1, 16'h0ABC});
        dwr(2'd1, 64'd0, 64'h8000_0000_0000_0000);
        check(!panic_valid && panic_offset == 16'h0, "R7 no BUSY no signature", {panic_valid, panic_offset}, 64'd0);
        dwr(2'd1, 64'h8000_0ABC_1234_5678, ALL);
        check(!panic_valid, "R7 wrong pattern", 64'(panic_valid), 64'd0);

        // R3/R4 all sources masked
        hwr(2'd2, 64'd3, 64'd3);
        dwr(2'd3, 64'd3, 64'd3);
        hwr(2'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        irqs(1'b0, 1'b0, "R3 R4 fully masked");

        // R8 idle cycles keep state
        repeat (5) tick();
        peek(2'd0, 64'h8000_0000_0000_5555, "R8 h2d held");
        peek(2'd1, 64'h8000_0ABC_1234_5678, "R8 d2h held");

        // random mix, compared by the per-cycle model
        for (int i = 0; i < 600; i++) begin
            logic [63:0] hm, dm;
            tick();
            case ($urandom % 4)
                0: hm = ALL; 1: hm = FLG; 2: hm = 64'd1 << ($urandom % 64);
                default: hm = {$urandom, $urandom};
            endcase
            case ($urandom % 4)
                0: dm = ALL; 1: dm = FLG; 2: dm = 64'd1 << ($urandom % 64);
                default: dm = {$urandom, $urandom};
            endcase
            host_wr_en = $urandom % 2; host_wr_sel = 2'($urandom); host_wr_mask = hm;
            host_wr_data = {$urandom, $urandom};
            dsp_wr_en = $urandom % 2; dsp_wr_sel = 2'($urandom); dsp_wr_mask = dm;
            dsp_wr_data = ($urandom % 3 == 0) ? {1'b1, 15'($urandom), 16'($urandom), 32'h0DEA_D000 | 32'($urandom % 4096)}
                                              : {$urandom, $urandom};
            host_rd_sel = 2'($urandom); dsp_rd_sel = 2'($urandom);
        end
        tick();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule